// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes the control-state update a 32-bit core applies when it takes an event: a reset request, a synchronous exception (general fault, trap or TLB miss) or an accepted interrupt. The core presents its current program counter, status word, the live T/S/M/Q flags, R15, the vector base and its delay-slot flag, together with the event requests and their codes. One cycle later the sequencer presents the new program counter pair, the new status word, the save-register values and the write strobes for the event-code, interrupt-code and trap registers.

When the new status word changes the effective general-register bank, the block pulses a swap strobe. The register file uses it to exchange its eight low registers with their shadow copies. An exception taken while the vector base is still zero is not vectored. The block raises a halt pulse instead.

Only one event is taken per cycle. Instruction execution, interrupt priority arbitration and memory access belong to the surrounding core.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_ni is low, pc_o=0xA0000000, npc_o=0xA0000002, sr_o=0x700000F0, fpscr_o=0x00040001, and every strobe output is 0.
- R2: Only one event class is taken per cycle, with priority reset request over exception request over interrupt request. The lower-priority requests in that cycle have no effect on any output.
- R3: A reset request, one cycle later, sets pc_o=0xA0000000, npc_o=0xA0000002 and sr_o=0x700000F0. This value has MD (bit 30), RB (bit 29) and BL (bit 28) set, the mask field (bits 7:4) all ones and FD (bit 15) clear. The request also pulses vbr_clr_o and fpscr_we_o with fpscr_o=0x00040001, and writes rst_code_i to expevt_o. It does not pulse save_o.
- R4: An exception with a non-zero vector base, or an interrupt, pulses save_o. ssr_o takes sr_i with bit 0 replaced by flag_t_i, bit 1 by flag_s_i, bit 8 by flag_q_i and bit 9 by flag_m_i. sgr_o takes r15_i.
- R5: The new pc_o is the vector base plus 0x100 for a general fault or a trap (exc_kind_i 0, 1 or 3), plus 0x400 for a TLB miss (exc_kind_i 2), and plus 0x600 for an interrupt.
- R6: On every update, npc_o equals pc_o + 2.
- R7: On exception or interrupt entry, sr_o equals ssr_o with bits 30, 29 and 28 forced to 1.
- R8: An exception raised in a delay slot sets spc_o to pc_i - 2, pulses slot_clr_o and writes exc_slot_code_i to expevt_o. Outside a delay slot, spc_o is pc_i and expevt_o is exc_code_i. Interrupts always save pc_i unchanged.
- R9: A trap (exc_kind_i 1) pulses tra_we_o with tra_o = trap_imm_i shifted left by 2, zero-extended.
- R10: bank_swap_o pulses exactly when the old effective bank (sr_i bits 30 and 29 both set) differs from that of the new status word.
- R11: An exception request with vbr_i equal to 0 pulses only halt_o. Every other strobe stays 0 and pc_o, npc_o, sr_o, spc_o, ssr_o, sgr_o, expevt_o and tra_o keep their values.
- R12: Each strobe lasts one cycle per accepted request. expevt_we_o pulses for reset and exceptions, intevt_we_o only for interrupts (with intevt_o = irq_code_i), and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| rst_req_i | input | 1 | Reset-class event request |
| rst_code_i | input | 12 | Event code for a reset request |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_kind_i | input | 2 | 0 general, 1 trap, 2 TLB miss, 3 general |
| exc_code_i | input | 12 | Exception code outside a delay slot |
| exc_slot_code_i | input | 12 | Exception code inside a delay slot |
| trap_imm_i | input | 8 | Trap immediate |
| irq_req_i | input | 1 | Accepted interrupt request |
| irq_code_i | input | 12 | Interrupt code |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| flag_t_i | input | 1 | Live T flag |
| flag_s_i | input | 1 | Live S flag |
| flag_m_i | input | 1 | Live M flag |
| flag_q_i | input | 1 | Live Q flag |
| r15_i | input | 32 | Current R15 |
| vbr_i | input | 32 | Vector base |
| in_slot_i | input | 1 | Faulting instruction is in a delay slot |
| upd_o | output | 1 | pc_o, npc_o and sr_o were updated |
| pc_o | output | 32 | New program counter |
| npc_o | output | 32 | New next program counter |
| sr_o | output | 32 | New status word |
| save_o | output | 1 | Save registers written |
| spc_o | output | 32 | Saved program counter |
| ssr_o | output | 32 | Saved status word |
| sgr_o | output | 32 | Saved R15 |
| slot_clr_o | output | 1 | Clear the delay-slot flag |
| expevt_we_o | output | 1 | Exception code write strobe |
| expevt_o | output | 12 | Exception code |
| intevt_we_o | output | 1 | Interrupt code write strobe |
| intevt_o | output | 12 | Interrupt code |
| tra_we_o | output | 1 | Trap register write strobe |
| tra_o | output | 32 | Trap register value |
| vbr_clr_o | output | 1 | Clear the vector base |
| fpscr_we_o | output | 1 | FPU status write strobe |
| fpscr_o | output | 32 | FPU status value |
| bank_swap_o | output | 1 | Swap the low general registers with their bank |
| halt_o | output | 1 | Exception with an unset vector base |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, 12-bit codes and vector offsets 0x100, 0x400 and 0x600. It sweeps every combination of the three request lines, all four exception kinds, the delay-slot flag, a zero and a non-zero vector base, and all four MD/RB settings. That reaches every priority conflict, every vector class, the halt path, both slot codes and every swap and no-swap case. The live flags, R15, the PC and the trap immediate change from case to case, so merge and shift errors show up in the saved values. After each case the bench checks that every strobe falls back to zero and that the held values are unchanged.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_RESET = 3'd1,
    CLS_GEN   = 3'd2,
    CLS_TRAP  = 3'd3,
    CLS_TLB   = 3'd4,
    CLS_IRQ   = 3'd5
  } ev_cls_e;

  localparam logic [1:0] KIND_TRAP = 2'd1;
  localparam logic [1:0] KIND_TLB  = 2'd2;

  localparam int SR_T  = 0;
  localparam int SR_S  = 1;
  localparam int SR_Q  = 8;
  localparam int SR_M  = 9;
  localparam int SR_FD = 15;
  localparam int SR_BL = 28;
  localparam int SR_RB = 29;
  localparam int SR_MD = 30;
  localparam int IMASK_LO = 4;
  localparam int IMASK_HI = 7;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic       rst_req_i,
  input  logic       exc_req_i,
  input  logic [1:0] exc_kind_i,
  input  logic       irq_req_i,
  output ev_cls_e    cls_o
);
  always_comb begin
    cls_o = CLS_NONE;
    if (rst_req_i)                cls_o = CLS_RESET;
    else if (exc_req_i) begin
      if (exc_kind_i == KIND_TRAP)     cls_o = CLS_TRAP;
      else if (exc_kind_i == KIND_TLB) cls_o = CLS_TLB;
      else                             cls_o = CLS_GEN;
    end
    else if (irq_req_i)           cls_o = CLS_IRQ;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 'hA000_0000,
  parameter logic [XLEN-1:0] VEC_GEN  = 'h100,
  parameter logic [XLEN-1:0] VEC_TLB  = 'h400,
  parameter logic [XLEN-1:0] VEC_IRQ  = 'h600
) (
  input  ev_cls_e         cls_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] vbr_i,
  input  logic            in_slot_i,
  output logic [XLEN-1:0] tgt_pc_o,
  output logic [XLEN-1:0] tgt_npc_o,
  output logic [XLEN-1:0] spc_o,
  output logic            halt_o
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(2);

  logic sync_exc;
  logic [XLEN-1:0] offs;

  assign sync_exc = (cls_i == CLS_GEN) || (cls_i == CLS_TRAP) || (cls_i == CLS_TLB);

  always_comb begin
    case (cls_i)
      CLS_TLB: offs = VEC_TLB;
      CLS_IRQ: offs = VEC_IRQ;
      default: offs = VEC_GEN;
    endcase
  end

  always_comb begin
    halt_o   = sync_exc && (vbr_i == '0);
    tgt_pc_o = (cls_i == CLS_RESET) ? RESET_PC : vbr_i + offs;
    // slot faults restart at the branch that owns the slot
    spc_o    = (sync_exc && in_slot_i) ? pc_i - INSN_BYTES : pc_i;
  end

  assign tgt_npc_o = tgt_pc_o + INSN_BYTES;
endmodule

// File: rtl/exc_sr_calc.sv
module exc_sr_calc
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_SR = 'h7000_00F0
) (
  input  ev_cls_e         cls_i,
  input  logic            halt_i,
  input  logic [XLEN-1:0] sr_i,
  input  logic            flag_t_i,
  input  logic            flag_s_i,
  input  logic            flag_m_i,
  input  logic            flag_q_i,
  output logic [XLEN-1:0] ssr_o,
  output logic [XLEN-1:0] sr_new_o,
  output logic            swap_o
);
  logic old_bank, new_bank, active;

  always_comb begin
    ssr_o       = sr_i;
    ssr_o[SR_T] = flag_t_i;
    ssr_o[SR_S] = flag_s_i;
    ssr_o[SR_M] = flag_m_i;
    ssr_o[SR_Q] = flag_q_i;
  end

  always_comb begin
    if (cls_i == CLS_RESET) begin
      sr_new_o = RESET_SR;
      sr_new_o[IMASK_HI:IMASK_LO] = '1;
      sr_new_o[SR_FD] = 1'b0;
    end else begin
      sr_new_o = ssr_o;
    end
    sr_new_o[SR_MD] = 1'b1;
    sr_new_o[SR_BL] = 1'b1;
    sr_new_o[SR_RB] = 1'b1;
  end

  assign active   = (cls_i != CLS_NONE) && !halt_i;
  assign old_bank = sr_i[SR_MD] & sr_i[SR_RB];
  assign new_bank = sr_new_o[SR_MD] & sr_new_o[SR_RB];
  assign swap_o   = active && (old_bank != new_bank);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     CODE_W      = 12,
  parameter int unsigned     IMM_W       = 8,
  parameter logic [XLEN-1:0] RESET_PC    = 'hA000_0000,
  parameter logic [XLEN-1:0] RESET_SR    = 'h7000_00F0,
  parameter logic [XLEN-1:0] RESET_FPSCR = 'h0004_0001,
  parameter logic [XLEN-1:0] VEC_GEN     = 'h100,
  parameter logic [XLEN-1:0] VEC_TLB     = 'h400,
  parameter logic [XLEN-1:0] VEC_IRQ     = 'h600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_req_i,
  input  logic [CODE_W-1:0] rst_code_i,
  input  logic              exc_req_i,
  input  logic [1:0]        exc_kind_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [CODE_W-1:0] exc_slot_code_i,
  input  logic [IMM_W-1:0]  trap_imm_i,
  input  logic              irq_req_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic              flag_t_i,
  input  logic              flag_s_i,
  input  logic              flag_m_i,
  input  logic              flag_q_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              in_slot_i,
  output logic              upd_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   npc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic              save_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic              slot_clr_o,
  output logic              expevt_we_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic              intevt_we_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic              tra_we_o,
  output logic [XLEN-1:0]   tra_o,
  output logic              vbr_clr_o,
  output logic              fpscr_we_o,
  output logic [XLEN-1:0]   fpscr_o,
  output logic              bank_swap_o,
  output logic              halt_o
);
  localparam int unsigned TRA_W = IMM_W + 2;

  ev_cls_e         cls;
  logic [XLEN-1:0] tgt_pc, tgt_npc, spc_n, ssr_n, sr_n;
  logic            halt_n, swap_n, sync_exc, take, save_n;

  exc_arbiter u_arb (
    .rst_req_i (rst_req_i),
    .exc_req_i (exc_req_i),
    .exc_kind_i(exc_kind_i),
    .irq_req_i (irq_req_i),
    .cls_o     (cls)
  );

  exc_vector #(
    .XLEN(XLEN), .RESET_PC(RESET_PC),
    .VEC_GEN(VEC_GEN), .VEC_TLB(VEC_TLB), .VEC_IRQ(VEC_IRQ)
  ) u_vec (
    .cls_i    (cls),
    .pc_i     (pc_i),
    .vbr_i    (vbr_i),
    .in_slot_i(in_slot_i),
    .tgt_pc_o (tgt_pc),
    .tgt_npc_o(tgt_npc),
    .spc_o    (spc_n),
    .halt_o   (halt_n)
  );

  exc_sr_calc #(.XLEN(XLEN), .RESET_SR(RESET_SR)) u_sr (
    .cls_i   (cls),
    .halt_i  (halt_n),
    .sr_i    (sr_i),
    .flag_t_i(flag_t_i),
    .flag_s_i(flag_s_i),
    .flag_m_i(flag_m_i),
    .flag_q_i(flag_q_i),
    .ssr_o   (ssr_n),
    .sr_new_o(sr_n),
    .swap_o  (swap_n)
  );

  assign sync_exc = (cls == CLS_GEN) || (cls == CLS_TRAP) || (cls == CLS_TLB);
  assign take     = (cls != CLS_NONE) && !halt_n;
  assign save_n   = take && (cls != CLS_RESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_o       <= 1'b0;
      pc_o        <= RESET_PC;
      npc_o       <= RESET_PC + XLEN'(2);
      sr_o        <= RESET_SR;
      save_o      <= 1'b0;
      spc_o       <= '0;
      ssr_o       <= '0;
      sgr_o       <= '0;
      slot_clr_o  <= 1'b0;
      expevt_we_o <= 1'b0;
      expevt_o    <= '0;
      intevt_we_o <= 1'b0;
      intevt_o    <= '0;
      tra_we_o    <= 1'b0;
      tra_o       <= '0;
      vbr_clr_o   <= 1'b0;
      fpscr_we_o  <= 1'b0;
      fpscr_o     <= RESET_FPSCR;
      bank_swap_o <= 1'b0;
      halt_o      <= 1'b0;
    end else begin
      upd_o       <= take;
      save_o      <= save_n;
      slot_clr_o  <= take && sync_exc && in_slot_i;
      expevt_we_o <= take && (cls != CLS_IRQ);
      intevt_we_o <= take && (cls == CLS_IRQ);
      tra_we_o    <= take && (cls == CLS_TRAP);
      vbr_clr_o   <= cls == CLS_RESET;
      fpscr_we_o  <= cls == CLS_RESET;
      bank_swap_o <= swap_n;
      halt_o      <= halt_n;
      if (take) begin
        pc_o  <= tgt_pc;
        npc_o <= tgt_npc;
        sr_o  <= sr_n;
      end
      if (save_n) begin
        spc_o <= spc_n;
        ssr_o <= ssr_n;
        sgr_o <= r15_i;
      end
      if (cls == CLS_RESET) begin
        expevt_o <= rst_code_i;
        fpscr_o  <= RESET_FPSCR;
      end else if (take && sync_exc) begin
        expevt_o <= in_slot_i ? exc_slot_code_i : exc_code_i;
      end
      if (take && (cls == CLS_IRQ)) intevt_o <= irq_code_i;
      if (take && (cls == CLS_TRAP)) tra_o <= XLEN'({trap_imm_i, 2'b00});
    end
  end

  logic [TRA_W-1:0] unused_tra_w;
  assign unused_tra_w = '0;

  a_r12_single_code_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(expevt_we_o && intevt_we_o));

  a_r6_npc_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> npc_o == pc_o + XLEN'(2));

  a_r7_priv_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |-> sr_o[SR_MD] && sr_o[SR_BL] && sr_o[SR_RB]);

  a_r11_halt_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !upd_o && !save_o && !expevt_we_o && !tra_we_o && !bank_swap_o);

  a_r2_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> fpscr_we_o && !save_o && !intevt_we_o && !halt_o);

  a_r8_slot_spc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !rst_req_i && in_slot_i && vbr_i != '0) |=>
      slot_clr_o && spc_o == $past(pc_i) - XLEN'(2));

  a_r9_trap_pairs_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tra_we_o |-> expevt_we_o && save_o);
endmodule

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rst_req_i = 0, exc_req_i = 0, irq_req_i = 0, in_slot_i = 0;
  logic [1:0]  exc_kind_i = 0;
  logic [11:0] rst_code_i = 12'h020, exc_code_i = 12'h0E0, exc_slot_code_i = 12'h1A0, irq_code_i = 12'h320;
  logic [7:0]  trap_imm_i = 0;
  logic [31:0] pc_i = 0, sr_i = 0, r15_i = 0, vbr_i = 0;
  logic        flag_t_i = 0, flag_s_i = 0, flag_m_i = 0, flag_q_i = 0;

  logic        upd_o, save_o, slot_clr_o, expevt_we_o, intevt_we_o, tra_we_o;
  logic        vbr_clr_o, fpscr_we_o, bank_swap_o, halt_o;
  logic [31:0] pc_o, npc_o, sr_o, spc_o, ssr_o, sgr_o, tra_o, fpscr_o;
  logic [11:0] expevt_o, intevt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected model state
  logic [31:0] e_pc, e_npc, e_sr, e_spc, e_ssr, e_sgr, e_tra, e_fp;
  logic [11:0] e_exp, e_int;
  logic e_upd, e_save, e_slot, e_expwe, e_intwe, e_trawe, e_vbrc, e_fpwe, e_swap, e_halt;

  always #2.5 clk_i = ~clk_i;

  exc_entry_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rst_req_i(rst_req_i), .rst_code_i(rst_code_i),
    .exc_req_i(exc_req_i), .exc_kind_i(exc_kind_i),
    .exc_code_i(exc_code_i), .exc_slot_code_i(exc_slot_code_i),
    .trap_imm_i(trap_imm_i), .irq_req_i(irq_req_i), .irq_code_i(irq_code_i),
    .pc_i(pc_i), .sr_i(sr_i),
    .flag_t_i(flag_t_i), .flag_s_i(flag_s_i), .flag_m_i(flag_m_i), .flag_q_i(flag_q_i),
    .r15_i(r15_i), .vbr_i(vbr_i), .in_slot_i(in_slot_i),
    .upd_o(upd_o), .pc_o(pc_o), .npc_o(npc_o), .sr_o(sr_o),
    .save_o(save_o), .spc_o(spc_o), .ssr_o(ssr_o), .sgr_o(sgr_o),
    .slot_clr_o(slot_clr_o),
    .expevt_we_o(expevt_we_o), .expevt_o(expevt_o),
    .intevt_we_o(intevt_we_o), .intevt_o(intevt_o),
    .tra_we_o(tra_we_o), .tra_o(tra_o),
    .vbr_clr_o(vbr_clr_o), .fpscr_we_o(fpscr_we_o), .fpscr_o(fpscr_o),
    .bank_swap_o(bank_swap_o), .halt_o(halt_o)
  );

  task automatic chk(input string req, input string name, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, name, act, exp);
    end
  endtask

  task automatic clr_strobes();
    e_upd = 0; e_save = 0; e_slot = 0; e_expwe = 0; e_intwe = 0;
    e_trawe = 0; e_vbrc = 0; e_fpwe = 0; e_swap = 0; e_halt = 0;
  endtask

  task automatic check_all(input string tag);
    chk("R5",  {tag, " pc"},        pc_o, e_pc);
    chk("R6",  {tag, " npc"},       npc_o, e_npc);
    chk("R7",  {tag, " sr"},        sr_o, e_sr);
    chk("R8",  {tag, " spc"},       spc_o, e_spc);
    chk("R4",  {tag, " ssr"},       ssr_o, e_ssr);
    chk("R4",  {tag, " sgr"},       sgr_o, e_sgr);
    chk("R4",  {tag, " save"},      32'(save_o), 32'(e_save));
    chk("R8",  {tag, " slot_clr"},  32'(slot_clr_o), 32'(e_slot));
    chk("R2",  {tag, " expevt_we"}, 32'(expevt_we_o), 32'(e_expwe));
    chk("R2",  {tag, " expevt"},    32'(expevt_o), 32'(e_exp));
    chk("R12", {tag, " intevt_we"}, 32'(intevt_we_o), 32'(e_intwe));
    chk("R12", {tag, " intevt"},    32'(intevt_o), 32'(e_int));
    chk("R9",  {tag, " tra_we"},    32'(tra_we_o), 32'(e_trawe));
    chk("R9",  {tag, " tra"},       tra_o, e_tra);
    chk("R3",  {tag, " vbr_clr"},   32'(vbr_clr_o), 32'(e_vbrc));
    chk("R3",  {tag, " fpscr_we"},  32'(fpscr_we_o), 32'(e_fpwe));
    chk("R3",  {tag, " fpscr"},     fpscr_o, e_fp);
    chk("R10", {tag, " bank_swap"}, 32'(bank_swap_o), 32'(e_swap));
    chk("R11", {tag, " halt"},      32'(halt_o), 32'(e_halt));
    chk("R6",  {tag, " upd"},       32'(upd_o), 32'(e_upd));
  endtask

  task automatic model_step();
    logic [31:0] merged;
    logic oldb;
    clr_strobes();
    merged = sr_i;
    merged[0] = flag_t_i; merged[1] = flag_s_i;
    merged[8] = flag_q_i; merged[9] = flag_m_i;
    oldb = sr_i[30] & sr_i[29];
    if (rst_req_i) begin
      e_upd = 1; e_pc = 32'hA000_0000; e_npc = 32'hA000_0002; e_sr = 32'h7000_00F0;
      e_vbrc = 1; e_fpwe = 1; e_fp = 32'h0004_0001;
      e_expwe = 1; e_exp = rst_code_i; e_swap = !oldb;
    end else if (exc_req_i) begin
      if (vbr_i == 0) begin
        e_halt = 1;
      end else begin
        e_upd = 1; e_save = 1;
        e_spc = in_slot_i ? pc_i - 2 : pc_i;
        e_ssr = merged; e_sgr = r15_i;
        e_sr = merged | 32'h7000_0000;
        e_pc = vbr_i + ((exc_kind_i == 2) ? 32'h400 : 32'h100);
        e_npc = e_pc + 2;
        e_expwe = 1; e_exp = in_slot_i ? exc_slot_code_i : exc_code_i;
        if (exc_kind_i == 1) begin e_trawe = 1; e_tra = {22'd0, trap_imm_i, 2'b00}; end
        e_slot = in_slot_i; e_swap = !oldb;
      end
    end else if (irq_req_i) begin
      e_upd = 1; e_save = 1; e_spc = pc_i; e_ssr = merged; e_sgr = r15_i;
      e_sr = merged | 32'h7000_0000;
      e_pc = vbr_i + 32'h600; e_npc = e_pc + 2;
      e_intwe = 1; e_int = irq_code_i; e_swap = !oldb;
    end
  endtask

  initial begin
    e_pc = 32'hA000_0000; e_npc = 32'hA000_0002; e_sr = 32'h7000_00F0;
    e_spc = 0; e_ssr = 0; e_sgr = 0; e_tra = 0; e_fp = 32'h0004_0001;
    e_exp = 0; e_int = 0;
    clr_strobes();
    repeat (3) @(negedge clk_i);
    check_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 idle");
    for (int idx = 0; idx < 512; idx++) begin
      // idx bits: [1:0] md/rb, [2] vbr zero, [3] slot, [5:4] kind, [8:6] requests
      rst_req_i  = idx[6];
      exc_req_i  = idx[7];
      irq_req_i  = idx[8];
      exc_kind_i = idx[5:4];
      in_slot_i  = idx[3];
      vbr_i      = idx[2] ? 32'h0 : 32'h8C00_0000 + 32'(idx[1:0]) * 32'h1_0000;
      sr_i       = 32'h0000_03F3 ^ {1'b0, idx[1], idx[0], 29'd0} ^ 32'(idx * 32'h0101);
      flag_t_i   = idx[0] ^ idx[4];
      flag_s_i   = idx[1] ^ idx[3];
      flag_m_i   = idx[2] ^ idx[5];
      flag_q_i   = ~idx[0];
      pc_i       = 32'h8C01_0000 + 32'(idx) * 4;
      r15_i      = 32'h8CFF_0000 - 32'(idx) * 16;
      trap_imm_i = 8'(idx * 37 + 5);
      rst_code_i = 12'h020 + 12'(idx[1:0]);
      exc_code_i = 12'h0E0 + 12'(idx[5:4]);
      exc_slot_code_i = 12'h1A0 + 12'(idx[5:4]);
      irq_code_i = 12'h200 + 12'(idx[4:0]) * 12'h20;
      model_step();
      @(negedge clk_i);
      check_all("R2 event");
      rst_req_i = 0; exc_req_i = 0; irq_req_i = 0;
      clr_strobes();
      @(negedge clk_i);
      check_all("R12 pulse end");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule